// File: doc/BRIEF.md
# Boot-Phase Command Gate

This block sits between a host-side mailbox and an embedded engine's command executor. It inspects every command word that the mailbox presents and decides, in the following cycle, whether the command goes on to the executor or comes back to the sender with an error code. The command executor itself lies outside this block.

Two one-shot notifications travel on the same command channel as ordinary commands. The first reports that the engine's reserved external memory is ready. The second marks the end of the boot phase. Each notification sets a flag that stays set until reset. A small policy computed from the opcode gives three things for each configuration command: whether it is known, whether it may run after boot, and whether it needs external memory.

The gate assumes that the boot firmware may misbehave. If a notification is missing, some commands are refused. A missing notification never makes a command pass that would otherwise fail. If boot ends without the memory notification, the engine stays in a degraded mode until reset.

Top module: `boot_cmd_gate`

## Requirements
- R1: During and after reset the gate gives no response, `degraded` is low, and both phase flags are clear.
- R2: Each cycle with `cmd_valid` high produces exactly one response (`rsp_valid` high) in the next cycle. A cycle with `cmd_valid` low produces no response in the next cycle.
- R3: Configuration opcodes are 0x00 to 0x0F. Before end-of-boot, such an opcode is accepted when it does not need memory, or when it needs memory and the memory flag is set.
- R4: After end-of-boot, a configuration opcode with bit 0 clear is rejected with error code 1 (phase). A configuration opcode with bit 0 set is judged as before.
- R5: Any opcode that is neither a configuration opcode nor a notification is rejected with error code 3 (unknown), in every phase.
- R6: A configuration opcode with bit 2 set needs external memory. While the memory flag is clear it is rejected with error code 2 (no memory). A phase rejection takes priority over this.
- R7: The memory notification is opcode 0xF0. Before end-of-boot it is accepted and sets the memory flag. After end-of-boot it is rejected with error code 1 and leaves the flag unchanged.
- R8: The end-of-boot notification is opcode 0xF1. The first one is accepted and sets the boot-done flag. Any later one is rejected with error code 1. No command ever clears a flag; only reset does.
- R9: `degraded` is high exactly when boot-done is set and the memory flag is clear. It changes in the same cycle as the response to the notification that caused the change.
- R10: An accepted response always carries error code 0, and a rejection always carries a non-zero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command word is present this cycle |
| cmd_op | input | 8 | Command or notification opcode |
| rsp_valid | output | 1 | Response strobe, one cycle after the command |
| rsp_accept | output | 1 | 1 = execute the command, 0 = rejected |
| rsp_err | output | 2 | 0 none, 1 phase, 2 no memory, 3 unknown |
| degraded | output | 1 | Boot ended without external memory |

## Verification
The bench targets the following corner cases:

- A memory notification that arrives after end-of-boot. A gate that honoured it would unlock memory-needing commands after boot, so those commands would be accepted instead of failing with code 2.
- A repeated end-of-boot notification. A gate that got this wrong would accept it, or would disturb the phase flags.
- A command that both breaks the post-boot rule and needs absent memory. A gate with the wrong error priority would report code 2 instead of code 1.
- Back-to-back commands straight after a notification. These show whether the new phase applies from the very next cycle.

A random run then mixes all opcode kinds and resets, and compares every cycle against a behavioural model.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_PHASE   = 2'd1,
        ERR_NOMEM   = 2'd2,
        ERR_UNKNOWN = 2'd3
    } gate_err_e;

    typedef struct packed {
        logic      valid;
        logic      accept;
        gate_err_e err;
    } gate_rsp_t;

    typedef struct packed {
        logic known;
        logic post_ok;
        logic needs_mem;
    } op_policy_t;

    typedef struct packed {
        logic mem_ready;
        logic boot_done;
    } phase_t;

endpackage

// File: rtl/bcg_policy.sv
module bcg_policy
    import bcg_pkg::*;
#(
    parameter int OP_W     = 8,
    parameter int NUM_CFG  = 16,
    parameter int POST_BIT = 0,
    parameter int MEM_BIT  = 2
) (
    input  logic [OP_W-1:0] op,
    output op_policy_t      pol
);
    localparam int IDX_W = $clog2(NUM_CFG);

    logic [NUM_CFG-1:0] post_tbl;
    logic [NUM_CFG-1:0] mem_tbl;

    // One table entry per configuration opcode, derived from its bit pattern.
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_tbl
        localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
        assign post_tbl[i] = IDX[POST_BIT];
        assign mem_tbl[i]  = IDX[MEM_BIT];
    end

    logic [IDX_W-1:0] idx;
    logic             in_range;

    always_comb begin
        in_range      = (op < OP_W'(NUM_CFG));
        idx           = op[IDX_W-1:0];
        pol.known     = in_range;
        pol.post_ok   = in_range & post_tbl[idx];
        pol.needs_mem = in_range & mem_tbl[idx];
    end

endmodule

// File: rtl/bcg_phase.sv
module bcg_phase
    import bcg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   set_mem,
    input  logic   set_eob,
    output phase_t ph_q
);
    phase_t ph_d;

    always_comb begin
        ph_d = ph_q;
        if (set_mem && !ph_q.boot_done) ph_d.mem_ready = 1'b1;
        if (set_eob)                    ph_d.boot_done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    // R8
    boot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.boot_done |=> ph_q.boot_done);
    // R8
    mem_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.mem_ready |=> ph_q.mem_ready);
    // R7
    late_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q.boot_done && !ph_q.mem_ready) |=> !ph_q.mem_ready);

endmodule

// File: rtl/bcg_decide.sv
module bcg_decide
    import bcg_pkg::*;
#(
    parameter int               OP_W     = 8,
    parameter logic [OP_W-1:0]  NOTE_MEM = 8'hF0,
    parameter logic [OP_W-1:0]  NOTE_EOB = 8'hF1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  op_policy_t      pol,
    input  phase_t          ph_q,
    output logic            set_mem,
    output logic            set_eob,
    output gate_rsp_t       rsp_q
);
    gate_rsp_t rsp_d;
    logic      is_mem_note;
    logic      is_eob_note;

    always_comb begin
        is_mem_note = (cmd_op == NOTE_MEM);
        is_eob_note = (cmd_op == NOTE_EOB);
        set_mem     = 1'b0;
        set_eob     = 1'b0;
        rsp_d       = '0;
        if (cmd_valid) begin
            rsp_d.valid = 1'b1;
            if (is_mem_note || is_eob_note) begin
                if (ph_q.boot_done) begin
                    rsp_d.err = ERR_PHASE;
                end else begin
                    rsp_d.accept = 1'b1;
                    set_mem      = is_mem_note;
                    set_eob      = is_eob_note;
                end
            end else if (!pol.known) begin
                rsp_d.err = ERR_UNKNOWN;
            end else if (ph_q.boot_done && !pol.post_ok) begin
                rsp_d.err = ERR_PHASE;
            end else if (pol.needs_mem && !ph_q.mem_ready) begin
                rsp_d.err = ERR_NOMEM;
            end else begin
                rsp_d.accept = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    // R2
    one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_q.valid);
    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_q.valid);
    // R10
    accept_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_q.valid && rsp_q.accept) |-> (rsp_q.err == ERR_NONE));
    // R10
    reject_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_q.valid && !rsp_q.accept) |-> (rsp_q.err != ERR_NONE));
    // R6
    nomem_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && pol.needs_mem && !ph_q.mem_ready) |=> !rsp_q.accept);
    // R5
    unknown_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !pol.known && !is_mem_note && !is_eob_note) |=>
        (!rsp_q.accept && rsp_q.err == ERR_UNKNOWN));

endmodule

// File: rtl/boot_cmd_gate.sv
module boot_cmd_gate
    import bcg_pkg::*;
#(
    parameter int              OP_W     = 8,
    parameter int              NUM_CFG  = 16,
    parameter int              POST_BIT = 0,
    parameter int              MEM_BIT  = 2,
    parameter logic [OP_W-1:0] NOTE_MEM = 8'hF0,
    parameter logic [OP_W-1:0] NOTE_EOB = 8'hF1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    output logic            rsp_valid,
    output logic            rsp_accept,
    output logic [1:0]      rsp_err,
    output logic            degraded
);
    op_policy_t pol;
    phase_t     ph_q;
    gate_rsp_t  rsp_q;
    logic       set_mem;
    logic       set_eob;

    bcg_policy #(
        .OP_W(OP_W), .NUM_CFG(NUM_CFG), .POST_BIT(POST_BIT), .MEM_BIT(MEM_BIT)
    ) u_policy (
        .op (cmd_op),
        .pol(pol)
    );

    bcg_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_mem(set_mem),
        .set_eob(set_eob),
        .ph_q   (ph_q)
    );

    bcg_decide #(
        .OP_W(OP_W), .NOTE_MEM(NOTE_MEM), .NOTE_EOB(NOTE_EOB)
    ) u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .pol      (pol),
        .ph_q     (ph_q),
        .set_mem  (set_mem),
        .set_eob  (set_eob),
        .rsp_q    (rsp_q)
    );

    assign rsp_valid  = rsp_q.valid;
    assign rsp_accept = rsp_q.accept;
    assign rsp_err    = rsp_q.err;
    assign degraded   = ph_q.boot_done & ~ph_q.mem_ready;

    // R9
    degraded_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(degraded) |-> (rsp_valid && rsp_accept));
    // R9
    degraded_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        degraded |=> degraded);

endmodule

// File: tb/sim_boot_cmd_gate.sv
module sim_boot_cmd_gate;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [7:0] cmd_op;
    logic       rsp_valid;
    logic       rsp_accept;
    logic [1:0] rsp_err;
    logic       degraded;

    always #4 clk = ~clk;

    boot_cmd_gate u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_err(rsp_err),
        .degraded(degraded)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    m_eob, m_mem;
    bit    e_valid, e_acc;
    int    e_err;
    string e_tag;

    task automatic check_outputs();
        n_chk++;
        if (rsp_valid !== e_valid) begin
            n_fail++;
            $display("FAIL %s rsp_valid actual=%0b expected=%0b", e_tag, rsp_valid, e_valid);
        end else if (e_valid && (rsp_accept !== e_acc || int'(rsp_err) != e_err)) begin
            n_fail++;
            $display("FAIL %s accept/err actual=%0b/%0d expected=%0b/%0d",
                     e_tag, rsp_accept, rsp_err, e_acc, e_err);
        end
        n_chk++;
        if (degraded !== (m_eob && !m_mem)) begin
            n_fail++;
            $display("FAIL R9 degraded actual=%0b expected=%0b", degraded, m_eob && !m_mem);
        end
    endtask

    // Behavioural reference: decide the outcome and advance the model flags.
    task automatic model(input bit v, input int op);
        e_valid = v;
        e_acc   = 1'b0;
        e_err   = 0;
        e_tag   = "R2";
        if (!v) return;
        if (op == 'hF0 || op == 'hF1) begin
            e_tag = (op == 'hF0) ? "R7" : "R8";
            if (m_eob) e_err = 1;
            else begin
                e_acc = 1'b1;
                if (op == 'hF0) m_mem = 1'b1;
                else            m_eob = 1'b1;
            end
        end else if (op > 'h0F) begin
            e_tag = "R5"; e_err = 3;
        end else if (m_eob && op[0] == 1'b0) begin
            e_tag = "R4"; e_err = 1;
        end else if (op[2] == 1'b1 && !m_mem) begin
            e_tag = "R6"; e_err = 2;
        end else begin
            e_tag = m_eob ? "R4" : "R3";
            e_acc = 1'b1;
        end
    endtask

    task automatic step(input bit v, input int op);
        @(negedge clk);
        check_outputs();
        cmd_valid = v;
        cmd_op    = 8'(op);
        model(v, op);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
        @(negedge clk);
        @(negedge clk);
        m_eob = 0; m_mem = 0; e_valid = 0; e_tag = "R1";
        check_outputs();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0;
        m_eob = 0; m_mem = 0; e_valid = 0; e_acc = 0; e_err = 0; e_tag = "R1";
        do_reset();                       // R1 reset state
        step(0, 0);
        // R3 / R6 before any notification
        for (int i = 0; i < 16; i++) step(1, i);
        step(1, 'h20); step(1, 'hF2); step(0, 0); step(1, 'hFF);   // R5
        step(1, 'hF0); step(1, 'h04); step(1, 'h06);               // R7 then memory commands
        step(1, 'hF0); step(1, 'h05);                              // R7 repeated
        step(1, 'hF1);                                             // R8
        for (int i = 0; i < 16; i++) step(1, i);                   // R4
        step(1, 'hF1); step(1, 'hF0); step(1, 'h30);               // R8 repeat, R7 late
        // Degraded path: boot ends without memory
        do_reset();
        step(1, 'h05); step(1, 'hF1); step(1, 'h05); step(1, 'h04);
        step(1, 'h01); step(1, 'hF0); step(1, 'h05); step(0, 0);   // R9 late memory ignored
        // Random mix with occasional resets
        for (int k = 0; k < 600; k++) begin
            int r, op;
            r = int'($urandom_range(0, 99));
            if (r < 2) do_reset();
            else begin
                if (r < 8)       op = 'hF0;
                else if (r < 13) op = 'hF1;
                else if (r < 20) op = int'($urandom_range(16, 255));
                else             op = int'($urandom_range(0, 15));
                step(r > 25 || r < 20, op);
            end
        end
        step(0, 0); step(0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule